// File: doc/BRIEF.md
# Addressable UART interrupt identifier

This block decides which interrupt a multidrop UART slave reports to its processor and recognises frames aimed at this node. The UART core hands it single-cycle event pulses: a received byte (marked as either an address byte or a data byte), a receive line error, transmit holding register empty, completion of an address-byte transmission, and a modem status change. Each source has its own pending flag. A source is latched only when its enable input is high. A received address byte becomes an event only if it equals the programmable own-address register. An address byte that does not match is dropped and raises nothing.

The block presents an identification word. `pendN` is an active-low pending flag. `srcCode` is a 3-bit source code that names the highest-priority pending source, and `irq` is the combined interrupt line. Register accesses on the bus are given as single-cycle strobes, and each access clears the sources it acknowledges. When the reported source clears, the next pending source is reported in that same cycle. The own-address register can be written through its own strobe and is always readable on `ownAddr`.

Top module: `uartIidTop`

## Requirements
- R1: After reset, `pendN` is 1, `srcCode` is 000, `irq` is 0 and `ownAddr` is 0xAA.
- R2: While no source is pending, `pendN` is 1 and `srcCode` is 000. At all times `irq` is the inverse of `pendN`.
- R3: A pulse on `addrWrEn` loads `addrWrData` into `ownAddr` at the next clock edge.
- R4: An address byte (`evRxByte` with `rxIsAddr`=1) equal to `ownAddr`, received while `enRxFull`=1, makes the block report code 110 from the next cycle. With `enRxFull`=0 the same byte raises nothing. A read of received data (`rdRx`) clears the source.
- R5: An address byte that differs from `ownAddr` is discarded and sets no pending source.
- R6: A data byte (`evRxByte` with `rxIsAddr`=0) received while `enRxFull`=1 reports code 010. `rdRx` clears it.
- R7: `evLineErr` with `enLine`=1 reports code 011. `rdLineSta` clears it.
- R8: `evAddrTxDone` with `enTxEmpty`=1 reports code 101. Two accesses clear it: `wrTx`, or `rdIid` in a cycle where code 101 is the one being reported.
- R9: `evTxEmpty` with `enTxEmpty`=1 reports code 001. Two accesses clear it: `wrTx`, or `rdIid` in a cycle where code 001 is the one being reported.
- R10: `evModem` with `enModem`=1 reports code 000 with `pendN`=0. `rdModemSta` clears it.
- R11: When several sources are pending, the order of precedence is fixed: line status (011), address match (110), receive full (010), address transmitted (101), transmit empty (001), modem (000). Once the reported source is cleared, the next pending source appears in the cycle after the clearing access.
- R12: An event whose enable input is low does not latch its source.
- R13: When a source's event and its clearing access come in the same cycle, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evRxByte | input | 1 | Byte received pulse |
| rxIsAddr | input | 1 | Received byte is an address byte |
| rxByte | input | 8 | Received byte value |
| evLineErr | input | 1 | Receive line error pulse |
| evTxEmpty | input | 1 | Transmit holding register empty pulse |
| evAddrTxDone | input | 1 | Address byte sent, transmit buffer empty pulse |
| evModem | input | 1 | Modem status change pulse |
| enLine | input | 1 | Enable for line status source |
| enRxFull | input | 1 | Enable for receive full and address match sources |
| enTxEmpty | input | 1 | Enable for transmit empty and address transmitted sources |
| enModem | input | 1 | Enable for modem status source |
| addrWrEn | input | 1 | Own-address register write strobe |
| addrWrData | input | 8 | Own-address write value |
| rdRx | input | 1 | Receive data register read strobe |
| wrTx | input | 1 | Transmit data register write strobe |
| rdLineSta | input | 1 | Line status register read strobe |
| rdModemSta | input | 1 | Modem status register read strobe |
| rdIid | input | 1 | Primary identification register read strobe |
| ownAddr | output | 8 | Own-address register contents |
| pendN | output | 1 | Active-low interrupt pending flag |
| srcCode | output | 3 | Code of the reported source |
| irq | output | 1 | Combined interrupt request |

## Verification
Several properties are checked on every cycle: the idle code and its agreement with `irq`, the load of the own address, the top-priority reporting of a line error and its clearing, and that mismatching or disabled address bytes stay silent. Some behaviour only shows up in the bench's sequences. The bench walks every combination of the six sources and clears them one at a time, which checks the full precedence order, the per-access clearing rules (including the reported-only clear on an identification read) and the set-over-clear collision. It also sweeps all 256 address byte values against a non-default own address.

// File: rtl/uartIidPkg.sv
package uartIidPkg;

  localparam int NUM_SRC = 6;

  // source slots, in precedence order (slot 0 wins)
  localparam int IDX_LINE   = 0;
  localparam int IDX_MATCH  = 1;
  localparam int IDX_RXFULL = 2;
  localparam int IDX_ADDRTX = 3;
  localparam int IDX_TXMT   = 4;
  localparam int IDX_MODEM  = 5;

  typedef struct packed {
    logic [NUM_SRC-1:0] setFlag;
    logic [NUM_SRC-1:0] clrFlag;
    logic               addrWr;
  } ctlStrobe_t;

  function automatic logic [2:0] srcCodeOf(input int idx);
    case (idx)
      IDX_LINE:   return 3'b011;
      IDX_MATCH:  return 3'b110;
      IDX_RXFULL: return 3'b010;
      IDX_ADDRTX: return 3'b101;
      IDX_TXMT:   return 3'b001;
      default:    return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/uartIidCtrl.sv
module uartIidCtrl
  import uartIidPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              evRxByte,
  input  logic              rxIsAddr,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              evLineErr,
  input  logic              evTxEmpty,
  input  logic              evAddrTxDone,
  input  logic              evModem,
  input  logic              enLine,
  input  logic              enRxFull,
  input  logic              enTxEmpty,
  input  logic              enModem,
  input  logic              addrWrEn,
  input  logic              rdRx,
  input  logic              wrTx,
  input  logic              rdLineSta,
  input  logic              rdModemSta,
  input  logic              rdIid,
  input  logic [DATA_W-1:0] ownAddr,
  input  logic [NUM_SRC-1:0] grant,
  output ctlStrobe_t        strobe
);

  logic addrHit;
  logic rxAddrEv;
  logic rxDataEv;

  assign addrHit  = (rxByte == ownAddr);
  assign rxAddrEv = evRxByte && rxIsAddr;
  assign rxDataEv = evRxByte && !rxIsAddr;

  always_comb begin
    strobe = '0;

    // event side: each source latches only through its enable
    strobe.setFlag[IDX_LINE]   = evLineErr && enLine;
    strobe.setFlag[IDX_MATCH]  = rxAddrEv && addrHit && enRxFull;
    strobe.setFlag[IDX_RXFULL] = rxDataEv && enRxFull;
    strobe.setFlag[IDX_ADDRTX] = evAddrTxDone && enTxEmpty;
    strobe.setFlag[IDX_TXMT]   = evTxEmpty && enTxEmpty;
    strobe.setFlag[IDX_MODEM]  = evModem && enModem;

    // access side: acknowledgements
    strobe.clrFlag[IDX_LINE]   = rdLineSta;
    strobe.clrFlag[IDX_MATCH]  = rdRx;
    strobe.clrFlag[IDX_RXFULL] = rdRx;
    strobe.clrFlag[IDX_ADDRTX] = wrTx || (rdIid && grant[IDX_ADDRTX]);
    strobe.clrFlag[IDX_TXMT]   = wrTx || (rdIid && grant[IDX_TXMT]);
    strobe.clrFlag[IDX_MODEM]  = rdModemSta;

    strobe.addrWr = addrWrEn;
  end

endmodule

// File: rtl/uartIidDatapath.sv
module uartIidDatapath
  import uartIidPkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] RESET_ADDR = 'hAA
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [DATA_W-1:0]  addrWrData,
  output logic [DATA_W-1:0]  ownAddr,
  output logic [NUM_SRC-1:0] grant,
  output logic               pendN,
  output logic [2:0]         srcCode
);

  logic [NUM_SRC-1:0] flags;

  // one pending flag per source; a new event beats a same-cycle clear
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    flags[g] <= 1'b0;
      else if (strobe.setFlag[g])   flags[g] <= 1'b1;
      else if (strobe.clrFlag[g])   flags[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ownAddr <= RESET_ADDR;
    else if (strobe.addrWr) ownAddr <= addrWrData;
  end

  // fixed-precedence pick of the lowest set slot
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (flags[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  always_comb begin
    srcCode = 3'b000;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) srcCode = srcCode | srcCodeOf(i);
    end
  end

  assign pendN = ~|flags;

endmodule

// File: rtl/uartIidTop.sv
module uartIidTop
  import uartIidPkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] RESET_ADDR = 'hAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evRxByte,
  input  logic              rxIsAddr,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              evLineErr,
  input  logic              evTxEmpty,
  input  logic              evAddrTxDone,
  input  logic              evModem,
  input  logic              enLine,
  input  logic              enRxFull,
  input  logic              enTxEmpty,
  input  logic              enModem,
  input  logic              addrWrEn,
  input  logic [DATA_W-1:0] addrWrData,
  input  logic              rdRx,
  input  logic              wrTx,
  input  logic              rdLineSta,
  input  logic              rdModemSta,
  input  logic              rdIid,
  output logic [DATA_W-1:0] ownAddr,
  output logic              pendN,
  output logic [2:0]        srcCode,
  output logic              irq
);

  ctlStrobe_t         strobe;
  logic [NUM_SRC-1:0] grant;

  uartIidCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .evRxByte     (evRxByte),
    .rxIsAddr     (rxIsAddr),
    .rxByte       (rxByte),
    .evLineErr    (evLineErr),
    .evTxEmpty    (evTxEmpty),
    .evAddrTxDone (evAddrTxDone),
    .evModem      (evModem),
    .enLine       (enLine),
    .enRxFull     (enRxFull),
    .enTxEmpty    (enTxEmpty),
    .enModem      (enModem),
    .addrWrEn     (addrWrEn),
    .rdRx         (rdRx),
    .wrTx         (wrTx),
    .rdLineSta    (rdLineSta),
    .rdModemSta   (rdModemSta),
    .rdIid        (rdIid),
    .ownAddr      (ownAddr),
    .grant        (grant),
    .strobe       (strobe)
  );

  uartIidDatapath #(.DATA_W(DATA_W), .RESET_ADDR(RESET_ADDR)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .addrWrData (addrWrData),
    .ownAddr    (ownAddr),
    .grant      (grant),
    .pendN      (pendN),
    .srcCode    (srcCode)
  );

  assign irq = ~pendN;

endmodule

// File: rtl/uartIidChecker.sv
module uartIidChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              evRxByte,
  input logic              rxIsAddr,
  input logic [DATA_W-1:0] rxByte,
  input logic              evLineErr,
  input logic              evTxEmpty,
  input logic              evAddrTxDone,
  input logic              evModem,
  input logic              enLine,
  input logic              enRxFull,
  input logic              addrWrEn,
  input logic [DATA_W-1:0] addrWrData,
  input logic              rdLineSta,
  input logic [DATA_W-1:0] ownAddr,
  input logic              pendN,
  input logic [2:0]        srcCode,
  input logic              irq
);

  logic otherEvents;
  assign otherEvents = evLineErr || evTxEmpty || evAddrTxDone || evModem;

  assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    pendN |-> (srcCode == 3'b000 && !irq));

  assert_own_addr_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    addrWrEn |=> (ownAddr == $past(addrWrData)));

  assert_match_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pendN && evRxByte && rxIsAddr && !enRxFull && !otherEvents) |=> pendN);

  assert_mismatch_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pendN && evRxByte && rxIsAddr && (rxByte != ownAddr) && !addrWrEn && !otherEvents)
      |=> pendN);

  assert_line_top_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evLineErr && enLine) |=> (!pendN && srcCode == 3'b011));

  assert_line_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdLineSta && !evLineErr && !pendN && srcCode == 3'b011)
      |=> !(!pendN && srcCode == 3'b011));

endmodule

bind uartIidTop uartIidChecker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .evRxByte     (evRxByte),
  .rxIsAddr     (rxIsAddr),
  .rxByte       (rxByte),
  .evLineErr    (evLineErr),
  .evTxEmpty    (evTxEmpty),
  .evAddrTxDone (evAddrTxDone),
  .evModem      (evModem),
  .enLine       (enLine),
  .enRxFull     (enRxFull),
  .addrWrEn     (addrWrEn),
  .addrWrData   (addrWrData),
  .rdLineSta    (rdLineSta),
  .ownAddr      (ownAddr),
  .pendN        (pendN),
  .srcCode      (srcCode),
  .irq          (irq)
);

// File: tb/uartIidTop_bench.sv
module uartIidTop_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       evRxByte, rxIsAddr, evLineErr, evTxEmpty, evAddrTxDone, evModem;
  logic [7:0] rxByte, addrWrData;
  logic       enLine, enRxFull, enTxEmpty, enModem;
  logic       addrWrEn, rdRx, wrTx, rdLineSta, rdModemSta, rdIid;
  logic [7:0] ownAddr;
  logic       pendN, irq;
  logic [2:0] srcCode;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uartIidTop u_uartIidTop (
    .clk(clk), .rstN(rstN), .evRxByte(evRxByte), .rxIsAddr(rxIsAddr), .rxByte(rxByte),
    .evLineErr(evLineErr), .evTxEmpty(evTxEmpty), .evAddrTxDone(evAddrTxDone),
    .evModem(evModem), .enLine(enLine), .enRxFull(enRxFull), .enTxEmpty(enTxEmpty),
    .enModem(enModem), .addrWrEn(addrWrEn), .addrWrData(addrWrData), .rdRx(rdRx),
    .wrTx(wrTx), .rdLineSta(rdLineSta), .rdModemSta(rdModemSta), .rdIid(rdIid),
    .ownAddr(ownAddr), .pendN(pendN), .srcCode(srcCode), .irq(irq)
  );

  // expected code for each slot, slot 0 has top precedence (R11)
  function automatic logic [2:0] codeOf(input int idx);
    case (idx)
      0: return 3'b011;
      1: return 3'b110;
      2: return 3'b010;
      3: return 3'b101;
      4: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int topSlot(input logic [5:0] v);
    for (int i = 0; i < 6; i++) if (v[i]) return i;
    return 6;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkState(input string req, input logic [5:0] v);
    int t;
    t = topSlot(v);
    chk({req, " pendN"}, pendN, (v == 0) ? 1 : 0);
    chk({req, " code"}, srcCode, (v == 0) ? 0 : codeOf(t));
    chk({req, " irq"}, irq, (v == 0) ? 0 : 1);
  endtask

  task automatic quiet();
    evRxByte = 0; rxIsAddr = 0; rxByte = 0; evLineErr = 0; evTxEmpty = 0;
    evAddrTxDone = 0; evModem = 0; addrWrEn = 0; addrWrData = 0;
    rdRx = 0; wrTx = 0; rdLineSta = 0; rdModemSta = 0; rdIid = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    quiet();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] model;
    rstN = 0;
    quiet();
    enLine = 1; enRxFull = 1; enTxEmpty = 1; enModem = 1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ownAddr", ownAddr, 8'hAA);
    chkState("R1", 6'b0);

    // R3 own-address write
    addrWrEn = 1; addrWrData = 8'h5A;
    tick();
    chk("R3 ownAddr", ownAddr, 8'h5A);

    // R4 R5 sweep all address byte values
    for (int a = 0; a < 256; a++) begin
      evRxByte = 1; rxIsAddr = 1; rxByte = 8'(a);
      tick();
      if (a == 8'h5A) chkState("R4 match", 6'b000010);
      else            chkState("R5 mismatch", 6'b0);
      rdRx = 1;
      tick();
      chkState("R4 clear by rdRx", 6'b0);
    end

    // R4 R12 matching address with receive enable off
    enRxFull = 0;
    evRxByte = 1; rxIsAddr = 1; rxByte = 8'h5A;
    tick();
    chkState("R4 gated", 6'b0);
    // R12 all events with every enable low
    enLine = 0; enTxEmpty = 0; enModem = 0;
    evRxByte = 1; evLineErr = 1; evTxEmpty = 1; evAddrTxDone = 1; evModem = 1;
    tick();
    chkState("R12 disabled", 6'b0);
    enLine = 1; enRxFull = 1; enTxEmpty = 1; enModem = 1;

    // R13 event beats same-cycle clear
    evLineErr = 1;
    tick();
    evLineErr = 1; rdLineSta = 1;
    tick();
    chkState("R13 set wins", 6'b000001);
    rdLineSta = 1;
    tick();
    chkState("R7 line cleared", 6'b0);

    // R6..R11 every subset of sources, drained one report at a time
    for (int m = 0; m < 64; m++) begin
      model = 6'(m);
      evLineErr    = model[0];
      evRxByte     = model[2];
      rxIsAddr     = 0;
      evAddrTxDone = model[3];
      evTxEmpty    = model[4];
      evModem      = model[5];
      tick();
      if (model[1]) begin
        evRxByte = 1; rxIsAddr = 1; rxByte = 8'h5A;
        tick();
      end
      chkState("R11 priority", model);
      for (int s = 0; s < 7 && model != 0; s++) begin
        case (topSlot(model))
          0: begin rdLineSta = 1; model[0] = 0; end                 // R7
          1: begin rdRx = 1; model[1] = 0; model[2] = 0; end        // R4
          2: begin rdRx = 1; model[2] = 0; end                      // R6
          3: begin                                                  // R8
            if (m[0]) begin wrTx = 1; model[3] = 0; model[4] = 0; end
            else begin rdIid = 1; model[3] = 0; end
          end
          4: begin                                                  // R9
            if (m[1]) begin wrTx = 1; model[4] = 0; end
            else begin rdIid = 1; model[4] = 0; end
          end
          default: begin rdModemSta = 1; model[5] = 0; end          // R10
        endcase
        tick();
        chkState("R11 next after clear", model);
      end
    end

    // R9 identification read leaves transmit-empty alone when not reported
    evTxEmpty = 1; evModem = 1; evLineErr = 1;
    tick();
    rdIid = 1;
    tick();
    chkState("R9 rdIid not reported", 6'b110001);
    rdLineSta = 1;
    tick();
    rdIid = 1;
    tick();
    chkState("R9 rdIid reported", 6'b100000);
    rdModemSta = 1;
    tick();
    chkState("R10 modem cleared", 6'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule